// File: doc/BRIEF.md
# Self-Recovering Maximal-Length Pseudorandom Reference Generator

This block produces a pseudorandom reference bit stream for a delay-modulation link. An 8-stage feedback shift register advances on each rising clock edge. The XOR of four stage outputs is fed back into stage 1. With the chosen taps, the stream repeats only after 255 clocks. The bit in stage 7 is the reference output. The whole state vector is also brought out so that downstream delay logic or a test can observe it.

An all-zero register is a fixed point of any XOR feedback, and the generator would stall there forever. A small zero-run counter watches stage 1 and tracks how long it has held 0. After eight zero clocks in a row, the counter forces a 1 into stage 1. Reset loads the all-zero state on purpose, so this recovery path runs every time the block starts up.

Top module: `prbs_ref_gen`

## Requirements
- R1: While rst_ni is low, state_o is 8'h00 and ref_o is 0, whether or not the clock is running. The reset acts asynchronously and also clears the zero-run counter.
- R2: state_o bit 0 is stage 1 and bit k is stage k+1. On every rising edge, each stage k+1 (k = 1..7) takes the old value of stage k.
- R3: The new value of stage 1 is the XOR of stages 8, 6, 5 and 4 (state_o bits 7, 5, 4, 3), ORed with the recovery force. This gives the polynomial x^8 + x^6 + x^5 + x^4 + 1.
- R4: Starting from any nonzero state, the register steps through exactly 255 distinct nonzero states and then returns to the starting state.
- R5: The 4-bit zero-run counter clears in the same edge that a 1 enters stage 1. Otherwise it increments, and it saturates at 15 instead of wrapping. After an injected 1 the next input bit again depends only on the taps: the state after the 10th edge following reset is 8'h02.
- R6: When counter bit 3 is set (eight consecutive zero entries into stage 1), a 1 is forced into stage 1. After reset, state_o stays 8'h00 through edge 8 and equals 8'h01 after edge 9.
- R7: ref_o equals stage 7 (state_o bit 6) at all times.
- R8: state_o is never 8'h00 for more than 9 consecutive rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; the register advances on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset; loads the all-zero state |
| state_o | output | 8 | Full register state; bit 0 is stage 1 |
| ref_o | output | 1 | Reference bit taken from stage 7 |

## Verification
The block has no data inputs, so the assertions assume only that rst_ni is asserted once before checking starts. They also assume that the zero-run counter begins each run from its cleared value. The stimulus releases reset on a falling clock edge, runs long enough to cover the start-up recovery and more than one full 255-state period, and then pulses reset asynchronously in the middle of a clock cycle. After that pulse it checks that recovery repeats from the same all-zero start.

// File: rtl/prbs_ref_pkg.sv
package prbs_ref_pkg;
  localparam int unsigned DefStages = 8;
  // stages 8,6,5,4 -> bits 7,5,4,3
  localparam logic [DefStages-1:0] DefTaps = 8'b1011_1000;
  localparam int unsigned DefRunW = 4;
  localparam int unsigned DefRefStage = 7;
endpackage

// File: rtl/prbs_lfsr_core.sv
module prbs_lfsr_core #(
  parameter int unsigned STAGES = prbs_ref_pkg::DefStages,
  parameter logic [STAGES-1:0] TAPS = prbs_ref_pkg::DefTaps
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              force_i,
  output logic              fill_o,
  output logic [STAGES-1:0] state_o
);
  logic [STAGES-1:0] state_q;
  logic              tap_par;

  assign tap_par = ^(state_q & TAPS);
  assign fill_o  = tap_par | force_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= '0;
    else         state_q <= {state_q[STAGES-2:0], fill_o};
  end

  assign state_o = state_q;
endmodule

// File: rtl/prbs_zero_guard.sv
module prbs_zero_guard #(
  parameter int unsigned RUN_W = prbs_ref_pkg::DefRunW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fill_i,
  output logic             force_o,
  output logic [RUN_W-1:0] run_o
);
  localparam logic [RUN_W-1:0] RunMax = '1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (fill_i)          run_q <= '0;
    else if (run_q != RunMax) run_q <= run_q + 1'b1;
  end

  // top bit flags a run as long as the register
  assign force_o = run_q[RUN_W-1];
  assign run_o   = run_q;
endmodule

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen #(
  parameter int unsigned STAGES = prbs_ref_pkg::DefStages,
  parameter logic [STAGES-1:0] TAPS = prbs_ref_pkg::DefTaps,
  parameter int unsigned RUN_W = prbs_ref_pkg::DefRunW,
  parameter int unsigned REF_STAGE = prbs_ref_pkg::DefRefStage
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [STAGES-1:0] state_o,
  output logic              ref_o
);
  localparam int unsigned RefIdx = REF_STAGE - 1;

  logic             force_w;
  logic             fill_w;
  logic [RUN_W-1:0] run_cnt;

  prbs_lfsr_core #(.STAGES(STAGES), .TAPS(TAPS)) i_core (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .force_i(force_w),
    .fill_o (fill_w),
    .state_o(state_o)
  );

  prbs_zero_guard #(.RUN_W(RUN_W)) i_guard (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fill_i (fill_w),
    .force_o(force_w),
    .run_o  (run_cnt)
  );

  assign ref_o = state_o[RefIdx];
endmodule

// File: rtl/prbs_ref_chk.sv
module prbs_ref_chk #(
  parameter int unsigned STAGES = 8,
  parameter int unsigned RUN_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [STAGES-1:0] state_i,
  input logic              ref_i,
  input logic [RUN_W-1:0]  run_i
);
  logic [4:0] zero_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           zero_len <= '0;
    else if (state_i != 0) zero_len <= '0;
    else if (zero_len != 5'h1f) zero_len <= zero_len + 1'b1;
  end

  assert_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> state_i[STAGES-1:1] == $past(state_i[STAGES-2:0]));

  assert_stay_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i != 0 |=> state_i != 0);

  assert_clear_on_one_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i[0] |-> run_i == 0);

  assert_inject_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i[RUN_W-1] |=> state_i[0]);

  assert_ref_tap_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ref_i == state_i[6]);

  assert_no_lockup_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_len <= 5'd9);
endmodule

bind prbs_ref_gen prbs_ref_chk #(.STAGES(STAGES), .RUN_W(RUN_W)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .state_i(state_o),
  .ref_i  (ref_o),
  .run_i  (run_cnt)
);

// File: tb/test_prbs_ref_gen.sv
module test_prbs_ref_gen;
  localparam int RunLen = 300;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] state_o;
  logic       ref_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_en  = 1'b0;
  bit done    = 1'b0;
  int edge_k  = 0;
  logic [7:0] exp_q[$];
  logic [7:0] obs [0:RunLen];

  always #10 clk_i = ~clk_i;

  prbs_ref_gen i_prbs_ref_gen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .state_o(state_o),
    .ref_o  (ref_o)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: models the spec and fills the scoreboard
  task automatic push_expected(input int n);
    logic [7:0] s = 8'h00;
    int zrun = 0;
    exp_q.delete();
    for (int i = 0; i < n; i++) begin
      logic fb;
      fb = s[7] ^ s[5] ^ s[4] ^ s[3];   // R3 polynomial
      if (zrun >= 8) fb = 1'b1;         // R6 forced one
      s = {s[6:0], fb};
      if (fb) zrun = 0; else if (zrun < 15) zrun++;   // R5
      exp_q.push_back(s);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (mon_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string tag;
      e = exp_q.pop_front();
      edge_k++;
      if (edge_k <= 9) tag = "R6";
      else if (edge_k == 10) tag = "R5";
      else tag = "R2/R3";
      check(tag, state_o, e);
      check("R7", {7'b0, ref_o}, {7'b0, state_o[6]});
      if (edge_k <= RunLen) obs[edge_k] = state_o;
    end
  end

  task automatic run_once(input bit log_period);
    push_expected(RunLen);
    edge_k = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    mon_en = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk_i);
    mon_en = 1'b0;
    if (log_period) begin
      bit seen [0:255];
      int distinct = 0;
      int max_zero = 0;
      int zr = 0;
      for (int i = 0; i < 256; i++) seen[i] = 1'b0;
      for (int k = 9; k < 9 + 255; k++) begin
        if (obs[k] != 0 && !seen[obs[k]]) distinct++;
        seen[obs[k]] = 1'b1;
      end
      check("R4", 8'(distinct == 255), 8'h01);
      check("R4", obs[9 + 255], obs[9]);
      for (int k = 1; k <= RunLen; k++) begin
        if (obs[k] == 0) zr++; else zr = 0;
        if (zr > max_zero) max_zero = zr;
      end
      check("R8", 8'(max_zero <= 9), 8'h01);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", state_o, 8'h00);
    check("R1", {7'b0, ref_o}, 8'h00);
    run_once(1'b1);
    // mid-cycle asynchronous reset
    @(posedge clk_i);
    #3 rst_ni = 1'b0;
    #2;
    check("R1", state_o, 8'h00);
    check("R1", {7'b0, ref_o}, 8'h00);
    repeat (2) @(negedge clk_i);
    check("R1", state_o, 8'h00);
    run_once(1'b0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule